// File: doc/BRIEF.md
# Single-Line NMI Interrupt Controller

This block watches one external non-maskable interrupt line and turns it into a single registered interrupt request for a parent interrupt controller. The raw line is first brought into the clock domain through a flop synchronizer. A 2-bit trigger field then decides what counts as an event: the line held low, the line held high, a rising transition or a falling transition. Each event latches a sticky pending flag. Software clears that flag by writing a one to it. The request leaves the block only while an enable bit is set.

Software reaches three registers (control, pending, enable) over a simple synchronous bus. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. A build parameter picks one of three address layouts for the pending and enable registers. In level modes, software clears the flag when it finishes service, and the flag comes back at once if the line is still active. In edge modes, software clears the flag as its acknowledge, before it handles the event, and a later transition sets the flag again.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0 and the control, pending and enable registers all read 0, which selects active-low level mode.
- R2: Control bits [1:0] select the trigger: 0 = line low (level), 1 = falling edge, 2 = line high (level), 3 = rising edge. The mode changes only when the control register is written.
- R3: The control register reads back every bit last written to it. Bits above [1:0] have no effect on triggering.
- R4: Pending is bit 0 of the pending register. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged.
- R5: Enable is bit 0 of the enable register, and its other bits read 0. When enable is 0 the request is held low and the pending flag is kept. Setting enable again with pending high raises `irq_out`.
- R6: In a level mode, the pending flag sets on every cycle in which the synchronized line sits at its active level, so a clear done while the line is active has no lasting effect.
- R7: In an edge mode, each transition of the selected polarity sets pending exactly once. After a clear, pending stays 0 until the next such transition, which sets it again.
- R8: A change on `nmi_in` reaches the pending flag on the third rising clock edge after it, and reaches `irq_out` one edge later (request = pending AND enable, registered).
- R9: If an event and a clearing write fall on the same edge, pending ends set.
- R10: Offsets by `LAYOUT`. 0: control 0x00, pending 0x04, enable 0x34. 1: control 0x00, pending 0x04, enable 0x08. 2: control 0x00, enable 0x04, pending 0x08.
- R11: Reads at offsets the layout does not define return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| nmi_in | input | 1 | Raw external interrupt line, asynchronous to clk |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_out | output | 1 | Registered interrupt request to the parent controller |

## Verification
A wrong pending state appears on the pending register read and on `irq_out` within one to two cycles. The bench therefore samples both at fixed cycle counts after each input change, not only once things have settled. The synchronizer depth and the edge memory show up only as timing, so the latency check counts each edge and requires pending to stay 0 until the third. A wrong clear-versus-set priority leaves a lost event that is visible only at the same-edge collision, and the bench places the clearing write on that edge on purpose. A decode error in one layout shows up as a register reading back at an offset where it should not, so all three layouts are checked side by side.

// File: rtl/nmi_line_pkg.sv
package nmi_line_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'd0,
    TRIG_FALL   = 2'd1,
    TRIG_LVL_HI = 2'd2,
    TRIG_RISE   = 2'd3
  } trig_mode_e;

  function automatic int unsigned ctrl_offset(int unsigned layout);
    ctrl_offset = (layout > 2) ? 0 : 0;
  endfunction

  function automatic int unsigned pend_offset(int unsigned layout);
    pend_offset = (layout == 2) ? 32'h08 : 32'h04;
  endfunction

  function automatic int unsigned en_offset(int unsigned layout);
    case (layout)
      0:       en_offset = 32'h34;
      1:       en_offset = 32'h08;
      default: en_offset = 32'h04;
    endcase
  endfunction

endpackage

// File: rtl/nmi_line_sync.sv
module nmi_line_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_raw,
  output logic lvl_s,
  output logic lvl_prev
);

  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= nmi_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign lvl_s    = stage_q[STAGES-1];
  assign lvl_prev = prev_q;

endmodule

// File: rtl/nmi_line_trig.sv
module nmi_line_trig
  import nmi_line_pkg::*;
(
  input  trig_mode_e mode,
  input  logic       lvl_s,
  input  logic       lvl_prev,
  output logic       set_evt
);

  always_comb begin
    unique case (mode)
      TRIG_LVL_LO: set_evt = ~lvl_s;
      TRIG_LVL_HI: set_evt = lvl_s;
      TRIG_FALL:   set_evt = lvl_prev & ~lvl_s;
      TRIG_RISE:   set_evt = ~lvl_prev & lvl_s;
      default:     set_evt = 1'b0;
    endcase
  end

endmodule

// File: rtl/nmi_line_regs.sv
module nmi_line_regs
  import nmi_line_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAYOUT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              set_evt,
  output logic [DATA_W-1:0] bus_rdata,
  output trig_mode_e        mode,
  output logic              pend_q,
  output logic              en_q
);

  localparam int unsigned CTRL_OFF = ctrl_offset(LAYOUT);
  localparam int unsigned PEND_OFF = pend_offset(LAYOUT);
  localparam int unsigned EN_OFF   = en_offset(LAYOUT);
  localparam logic [ADDR_W-1:0] CTRL_A = CTRL_OFF[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] PEND_A = PEND_OFF[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] EN_A   = EN_OFF[ADDR_W-1:0];

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] ctrl_d;
  logic              pend_d;
  logic              en_d;
  logic              hit_ctrl, hit_pend, hit_en;
  logic              ctrl_ld, en_ld, pend_clr;

  assign hit_ctrl = (bus_addr == CTRL_A);
  assign hit_pend = (bus_addr == PEND_A);
  assign hit_en   = (bus_addr == EN_A);

  assign ctrl_ld  = bus_wr & hit_ctrl;
  assign en_ld    = bus_wr & hit_en;
  assign pend_clr = bus_wr & hit_pend & bus_wdata[0];

  always_comb begin
    ctrl_d = ctrl_q;
    en_d   = en_q;
    if (ctrl_ld) ctrl_d = bus_wdata;
    if (en_ld)   en_d   = bus_wdata[0];
    pend_d = set_evt | (pend_q & ~pend_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ctrl_ld) ctrl_q <= ctrl_d;
      if (en_ld)   en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign mode = trig_mode_e'(ctrl_q[1:0]);

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)      bus_rdata = ctrl_q;
    else if (hit_pend) bus_rdata[0] = pend_q;
    else if (hit_en)   bus_rdata[0] = en_q;
  end

endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
  import nmi_line_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned LAYOUT      = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        IDLE_LVL    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);

  logic       lvl_s, lvl_prev, set_evt, pend_q, en_q, irq_d;
  trig_mode_e mode;

  nmi_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
    .clk(clk), .rst_n(rst_n), .nmi_raw(nmi_in),
    .lvl_s(lvl_s), .lvl_prev(lvl_prev)
  );

  nmi_line_trig u_trig (
    .mode(mode), .lvl_s(lvl_s), .lvl_prev(lvl_prev), .set_evt(set_evt)
  );

  nmi_line_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT(LAYOUT)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .set_evt(set_evt), .bus_rdata(bus_rdata),
    .mode(mode), .pend_q(pend_q), .en_q(en_q)
  );

  assign irq_d = pend_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= irq_d;
  end

endmodule

// File: rtl/nmi_line_chk.sv
module nmi_line_chk
  import nmi_line_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LAYOUT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              wdata_lsb,
  input logic              set_evt,
  input logic              pend_q,
  input logic              en_q,
  input logic              lvl_s,
  input logic              lvl_prev,
  input logic [1:0]        mode,
  input logic              irq_out
);

  localparam int unsigned PEND_OFF = pend_offset(LAYOUT);
  localparam int unsigned CTRL_OFF = ctrl_offset(LAYOUT);
  localparam logic [ADDR_W-1:0] PEND_A = PEND_OFF[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] CTRL_A = CTRL_OFF[ADDR_W-1:0];

  logic clr_wr, ctrl_wr;
  assign clr_wr  = bus_wr && (bus_addr == PEND_A) && wdata_lsb;
  assign ctrl_wr = bus_wr && (bus_addr == CTRL_A);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend_q);

  // R4
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !set_evt) |=> !pend_q);

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && !set_evt) |=> $stable(pend_q));

  // R7
  edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && mode[0]) |-> (lvl_s != lvl_prev));

  // R6
  level_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[0] && (lvl_s == mode[1])) |=> pend_q);

  // R5
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && $past(!en_q)) |-> !irq_out);

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(mode));

endmodule

bind nmi_line_ctrl nmi_line_chk #(.ADDR_W(ADDR_W), .LAYOUT(LAYOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .wdata_lsb(bus_wdata[0]), .set_evt(set_evt), .pend_q(pend_q), .en_q(en_q),
  .lvl_s(lvl_s), .lvl_prev(lvl_prev), .mode(mode), .irq_out(irq_out)
);

// File: tb/tb_nmi_line_ctrl.sv
`timescale 1ns/1ps
module tb_nmi_line_ctrl;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_PEND = 8'h04;
  localparam logic [7:0] A_EN   = 8'h08;

  // {mode[1:0], line before, line after, expected pending}
  localparam logic [4:0] VEC [0:9] = '{
    {2'd0, 1'b1, 1'b1, 1'b0},
    {2'd0, 1'b1, 1'b0, 1'b1},
    {2'd2, 1'b0, 1'b0, 1'b0},
    {2'd2, 1'b0, 1'b1, 1'b1},
    {2'd3, 1'b0, 1'b1, 1'b1},
    {2'd3, 1'b1, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b0},
    {2'd1, 1'b1, 1'b0, 1'b1},
    {2'd1, 1'b0, 1'b1, 1'b0},
    {2'd1, 1'b0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_in;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] rdata_b, rdata_a, rdata_c;
  logic        irq_b, irq_a, irq_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  nmi_line_ctrl dut (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .irq_out(irq_b)
  );

  nmi_line_ctrl #(.LAYOUT(0)) dut_a (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .irq_out(irq_a)
  );

  nmi_line_ctrl #(.LAYOUT(2)) dut_c (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata_c), .irq_out(irq_c)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    bus_addr = a;
    bus_wr   = 1'b0;
    #1;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; nmi_in = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 irq", {31'b0, irq_b}, 0);
    rd(A_CTRL); chk("R1 ctrl", rdata_b, 0);
    rd(A_PEND); chk("R1 pend", rdata_b, 0);
    rd(A_EN);   chk("R1 en", rdata_b, 0);

    // R2/R5 table of trigger modes and line patterns
    for (int i = 0; i < 10; i++) begin
      logic [1:0] m;
      logic b, a, e;
      {m, b, a, e} = VEC[i];
      wr(A_CTRL, {30'b0, m});
      nmi_in = b;
      idle(6);
      wr(A_PEND, 1);
      wr(A_EN, 1);
      nmi_in = a;
      idle(6);
      rd(A_PEND);
      chk($sformatf("R2 vec%0d pend", i), rdata_b, {31'b0, e});
      chk($sformatf("R5 vec%0d irq", i), {31'b0, irq_b}, {31'b0, e});
    end

    // R8 latency: rising mode, count edges after the line changes
    wr(A_CTRL, 3);
    nmi_in = 1'b0;
    idle(6);
    wr(A_PEND, 1);
    @(negedge clk); bus_addr = A_PEND; nmi_in = 1'b1;
    @(negedge clk); #1 chk("R8 edge1 pend", rdata_b, 0);
    @(negedge clk); #1 chk("R8 edge2 pend", rdata_b, 0);
    @(negedge clk); #1 chk("R8 edge3 pend", rdata_b, 1);
    chk("R8 edge3 irq", {31'b0, irq_b}, 0);
    @(negedge clk); #1 chk("R8 edge4 irq", {31'b0, irq_b}, 1);

    // R9 set and clear on the same edge
    nmi_in = 1'b0;
    idle(6);
    wr(A_PEND, 1);
    @(negedge clk); nmi_in = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = A_PEND; bus_wdata = 1; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; #1;
    chk("R9 set wins", rdata_b, 1);

    // R7 one set per transition, re-set after clear
    wr(A_PEND, 1);
    idle(6);
    rd(A_PEND); chk("R7 no re-set while high", rdata_b, 0);
    nmi_in = 1'b0; idle(3); nmi_in = 1'b1; idle(6);
    rd(A_PEND); chk("R7 new edge sets", rdata_b, 1);

    // R4 writing zero leaves pending
    wr(A_PEND, 0);
    rd(A_PEND); chk("R4 write zero", rdata_b, 1);

    // R5 masking keeps pending, unmask raises request
    wr(A_EN, 0);
    idle(2);
    chk("R5 masked irq", {31'b0, irq_b}, 0);
    rd(A_PEND); chk("R5 pend kept", rdata_b, 1);
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN); chk("R5 en readback", rdata_b, 1);
    idle(2);
    chk("R5 unmasked irq", {31'b0, irq_b}, 1);

    // R6 clear during active level
    wr(A_CTRL, 2);
    nmi_in = 1'b1;
    idle(6);
    wr(A_PEND, 1);
    rd(A_PEND); chk("R6 re-set at once", rdata_b, 1);
    nmi_in = 1'b0; idle(6);
    wr(A_PEND, 1);
    rd(A_PEND); chk("R6 clears when idle", rdata_b, 0);

    // R3 full readback, upper bits inert
    nmi_in = 1'b1;
    idle(3);
    wr(A_CTRL, 32'hABCD_EF00);
    rd(A_CTRL); chk("R3 readback", rdata_b, 32'hABCD_EF00);
    idle(6);
    wr(A_PEND, 1);
    idle(6);
    rd(A_PEND); chk("R3 upper bits inert", rdata_b, 0);
    wr(A_CTRL, 32'h1234_5673);
    rd(A_CTRL); chk("R3 readback2", rdata_b, 32'h1234_5673);

    // R11 undefined offsets
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h34, 0);
    rd(8'h10); chk("R11 undefined read", rdata_b, 0);
    rd(A_CTRL); chk("R11 ctrl untouched", rdata_b, 32'h1234_5673);
    rd(A_EN);   chk("R11 en untouched", rdata_b, 1);

    // R10 layouts side by side
    wr(8'h34, 1);
    rd(8'h34);
    chk("R10 layout0 en at 0x34", rdata_a, 1);
    chk("R10 layout1 0x34 undefined", rdata_b, 0);
    rd(8'h08); chk("R10 layout0 0x08 undefined", rdata_a, 0);
    wr(8'h04, 1);
    rd(8'h04); chk("R10 layout2 en at 0x04", rdata_c, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule